// File: doc/BRIEF.md
# Programmable BCD Ratio Divider

This block divides a free-running input clock by a decimal ratio N given as five packed BCD digits. It sits in the feedback path of a frequency synthesizer: the divided clock is a one-cycle-wide pulse that fires once every N input clocks. A phase comparator downstream compares it with a reference.

The count is held in a chain of decimal decades that count down. Every decade register runs on the same clock edge. The borrow from a lower decade only enables the next decade to count; it never clocks it.

The terminal count is 1, not 0. That decode is registered, and the registered flag drives the reload and is also the output pulse. The flag arrives one clock after the decode, so the reload writes N-1 instead of N. This keeps the period at exactly N clocks.

The ratio input is sampled on two edges only: the synchronous-reset edge, and the edge that closes each pulse cycle. Changing the ratio therefore never cuts short or stretches a period that is already running.

Top module: `bcd_ratio_divider`

## Requirements
- R1: Decimal digit k of the ratio sits at `ratioBcd[4k+3:4k]`, with digit 0 as the least significant. Every internal decade always holds a value from 0 to 9.
- R2: For 2 <= N <= 99999, `tick` is high for exactly one clock per pulse, and consecutive pulses are exactly N clocks apart.
- R3: `srst` is synchronous. After any clock edge with `srst` high, `tick` is low. The first pulse comes in the cycle that begins N rising edges after the last reset edge, and a reset in the middle of a count restarts the count.
- R4: The ratio is sampled only on a reset edge and on the edge that ends a pulse cycle. A change applied at any other time does not alter the period in progress.
- R5: A ratio of 0 or 1 gives divide-by-1, with `tick` high in every cycle.
- R6: A digit value from 10 to 15 is treated as 9. For example, 0x0000F divides by 9 and 0x000A0 divides by 90.
- R7: Borrows pass across decade boundaries without losing or adding cycles. Ratios such as 10, 123, 1000 and 10000 give exact periods.
- R8: `tick` comes from a register. It is high in the cycle that immediately follows the cycle in which the count held the value 1, and at no other time except under divide-by-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock to be divided |
| srst | input | 1 | Synchronous reset, active high; presets the counter from `ratioBcd` |
| ratioBcd | input | 20 | Division ratio as five BCD digits, least significant digit in bits 3:0 |
| tick | output | 1 | One-cycle pulse, once per N input clocks |

## Verification
Two functions can fall in the same cycle: the registered reload that closes a period, and a change of the ratio input.

The bench changes the ratio in three places and checks the pulse times that follow:
- in the middle of a period;
- inside the pulse cycle itself;
- one cycle after the pulse cycle.

Only the change made inside the pulse cycle may set the next period. The same overlap is also tested across the divide-by-1 boundary. Moving from 5 to 1 and from 1 to 4 makes the continuous-pulse mode and the reload meet on one edge. The bench then checks that neither an extra pulse nor a missing pulse appears.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  // Mutually exclusive strobes from control to datapath
  typedef struct packed {
    logic preset;  // load the clamped ratio (reset edge)
    logic reload;  // load the clamped ratio minus one (end of pulse cycle)
    logic count;   // decrement the decade chain
  } bdrStrobe_t;
endpackage

// File: rtl/bdr_decade.sv
module bdr_decade
  import bdr_pkg::*;
(
  input  logic               clk,
  input  logic               loadEn,
  input  logic [DIGIT_W-1:0] loadVal,
  input  logic               cntEn,
  output logic [DIGIT_W-1:0] digit
);
  // Shared clock; the enable decides whether this decade moves.
  always_ff @(posedge clk) begin
    if (loadEn) begin
      digit <= loadVal;
    end else if (cntEn) begin
      digit <= (digit == '0) ? DIGIT_MAX : digit - DIGIT_W'(1);
    end
  end
endmodule

// File: rtl/bdr_datapath.sv
module bdr_datapath
  import bdr_pkg::*;
#(
  parameter int DIGITS = 5,
  localparam int RATIO_W = DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  bdrStrobe_t         strobe,
  input  logic [RATIO_W-1:0] ratioBcd,
  output logic [RATIO_W-1:0] countFlat,
  output logic               countIsOne,
  output logic               ratioIsUnit
);
  logic [RATIO_W-1:0] clampFlat;
  logic [RATIO_W-1:0] clampFixed;
  logic [RATIO_W-1:0] decFlat;
  logic [RATIO_W-1:0] loadFlat;
  logic [DIGITS-1:0]  decBorrow;
  logic [DIGITS-1:0]  cntEnChain;
  logic               loadEn;

  // Clamp each digit into 0..9
  for (genvar i = 0; i < DIGITS; i++) begin : g_clamp
    logic [DIGIT_W-1:0] rawD;
    assign rawD = ratioBcd[i*DIGIT_W +: DIGIT_W];
    assign clampFlat[i*DIGIT_W +: DIGIT_W] = (rawD > DIGIT_MAX) ? DIGIT_MAX : rawD;
  end

  // A ratio of zero behaves like one
  assign clampFixed  = (clampFlat == '0) ? RATIO_W'(1) : clampFlat;
  assign ratioIsUnit = (clampFixed == RATIO_W'(1));

  // BCD minus-one of the clamped ratio; never underflows since ratio >= 1
  assign decBorrow[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    logic [DIGIT_W-1:0] srcD;
    assign srcD = clampFixed[i*DIGIT_W +: DIGIT_W];
    assign decFlat[i*DIGIT_W +: DIGIT_W] =
      decBorrow[i] ? ((srcD == '0) ? DIGIT_MAX : srcD - DIGIT_W'(1)) : srcD;
    if (i < DIGITS - 1) begin : g_next
      assign decBorrow[i+1] = decBorrow[i] && (srcD == '0);
    end
  end

  assign loadEn   = strobe.preset || strobe.reload;
  assign loadFlat = strobe.preset ? clampFixed : decFlat;

  // Borrow ripple used purely as count enables
  assign cntEnChain[0] = strobe.count;
  for (genvar i = 0; i < DIGITS; i++) begin : g_decade
    bdr_decade u_decade (
      .clk     (clk),
      .loadEn  (loadEn),
      .loadVal (loadFlat[i*DIGIT_W +: DIGIT_W]),
      .cntEn   (cntEnChain[i]),
      .digit   (countFlat[i*DIGIT_W +: DIGIT_W])
    );
    if (i < DIGITS - 1) begin : g_borrow
      assign cntEnChain[i+1] = cntEnChain[i] && (countFlat[i*DIGIT_W +: DIGIT_W] == '0);
    end
  end

  assign countIsOne = (countFlat == RATIO_W'(1));
endmodule

// File: rtl/bdr_control.sv
module bdr_control
  import bdr_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       countIsOne,
  input  logic       ratioIsUnit,
  output bdrStrobe_t strobe,
  output logic       tick
);
  logic reloadPend;

  // Registered terminal decode: count 1 now means reload next cycle
  always_ff @(posedge clk) begin
    if (srst) begin
      reloadPend <= 1'b0;
    end else if (reloadPend) begin
      reloadPend <= ratioIsUnit;
    end else begin
      reloadPend <= countIsOne;
    end
  end

  always_comb begin
    strobe.preset = srst;
    strobe.reload = !srst && reloadPend;
    strobe.count  = !srst && !reloadPend;
  end

  assign tick = reloadPend;
endmodule

// File: rtl/bcd_ratio_divider.sv
module bcd_ratio_divider
  import bdr_pkg::*;
#(
  parameter int DIGITS = 5,
  localparam int RATIO_W = DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  logic               srst,
  input  logic [RATIO_W-1:0] ratioBcd,
  output logic               tick
);
  bdrStrobe_t         strobe;
  logic [RATIO_W-1:0] countFlat;
  logic               countIsOne;
  logic               ratioIsUnit;

  bdr_control u_ctrl (
    .clk         (clk),
    .srst        (srst),
    .countIsOne  (countIsOne),
    .ratioIsUnit (ratioIsUnit),
    .strobe      (strobe),
    .tick        (tick)
  );

  bdr_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .ratioBcd    (ratioBcd),
    .countFlat   (countFlat),
    .countIsOne  (countIsOne),
    .ratioIsUnit (ratioIsUnit)
  );
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker
  import bdr_pkg::*;
#(
  parameter int DIGITS = 5,
  localparam int RATIO_W = DIGITS * DIGIT_W
) (
  input logic               clk,
  input logic               srst,
  input logic [RATIO_W-1:0] ratioBcd,
  input logic               tick,
  input logic [RATIO_W-1:0] countFlat
);
  logic unitRatio;
  assign unitRatio = (ratioBcd[RATIO_W-1:DIGIT_W] == '0) && (ratioBcd[DIGIT_W-1:0] <= DIGIT_W'(1));

  for (genvar i = 0; i < DIGITS; i++) begin : g_range
    // R1
    digit_range_chk: assert property (@(posedge clk) disable iff (srst)
      countFlat[i*DIGIT_W +: DIGIT_W] <= DIGIT_MAX);
  end

  // R3
  reset_quiet_chk: assert property (@(posedge clk) srst |=> !tick);

  // R8
  decode_one_chk: assert property (@(posedge clk) disable iff (srst)
    (!tick && countFlat == RATIO_W'(1)) |=> tick);

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (srst)
    (!tick && countFlat != RATIO_W'(1)) |=> !tick);

  // R5
  unit_ratio_chk: assert property (@(posedge clk) disable iff (srst)
    (tick && unitRatio) |=> tick);
endmodule

bind bcd_ratio_divider bdr_checker #(.DIGITS(DIGITS)) chk (
  .clk       (clk),
  .srst      (srst),
  .ratioBcd  (ratioBcd),
  .tick      (tick),
  .countFlat (countFlat)
);

// File: tb/bcd_ratio_divider_test.sv
module bcd_ratio_divider_test;
  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [19:0] ratioBcd = 20'h00005;
  logic        tick;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    base = 0;
  bit    quiet = 1'b1;
  bit    done = 1'b0;
  int    expCyc[$];
  string expTag[$];

  bcd_ratio_divider uut (
    .clk      (clk),
    .srst     (srst),
    .ratioBcd (ratioBcd),
    .tick     (tick)
  );

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected pulse cycles and compares
  always @(negedge clk) begin
    if (!quiet && tick) begin
      checks++;
      if (expCyc.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected tick at cycle %0d expected none", cyc - base);
      end else begin
        int e;
        string t;
        e = expCyc.pop_front();
        t = expTag.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL %s tick at rel cycle %0d expected %0d", t, cyc - base, e - base);
        end
      end
    end
  end

  task automatic expectAt(input int rel, input string tag);
    expCyc.push_back(base + rel);
    expTag.push_back(tag);
  endtask

  task automatic stepTo(input int rel);
    while (cyc < base + rel) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Reset with a new ratio; also checks the quiet output after the reset edge (R3)
  task automatic segStart(input logic [19:0] ratio);
    @(posedge clk);
    #2;
    quiet = 1'b1;
    srst = 1'b1;
    ratioBcd = ratio;
    @(posedge clk);
    #2;
    checks++;
    if (tick !== 1'b0) begin
      errors++;
      $display("FAIL R3 tick during reset actual %0b expected 0", tick);
    end
    srst = 1'b0;
    base = cyc;
    quiet = 1'b0;
  endtask

  task automatic segEnd(input int lastRel, input string tag);
    stepTo(lastRel + 1);
    quiet = 1'b1;
    checks++;
    if (expCyc.size() != 0) begin
      errors++;
      $display("FAIL %s missing pulses actual %0d left expected 0", tag, expCyc.size());
      expCyc.delete();
      expTag.delete();
    end
  endtask

  task automatic periodic(input logic [19:0] ratio, input int n, input int count, input string tag);
    segStart(ratio);
    for (int k = 1; k <= count; k++) expectAt(k * n, tag);
    segEnd(n * count, tag);
  endtask

  initial begin
    fork
      begin
        // R2 R3 R8: basic ratio, first pulse N edges after reset
        periodic(20'h00005, 5, 4, "R2");
        periodic(20'h00002, 2, 4, "R2 R8");
        // R5: divide-by-1 from 1 and 0
        periodic(20'h00001, 1, 6, "R5");
        periodic(20'h00000, 1, 5, "R5");
        // R1 R7: decade borrows
        periodic(20'h00010, 10, 3, "R7");
        periodic(20'h00123, 123, 2, "R1 R7");
        periodic(20'h01000, 1000, 1, "R7");
        periodic(20'h10000, 10000, 1, "R7");
        // R6: digit clamp
        periodic(20'h0000F, 9, 2, "R6");
        periodic(20'h000A0, 90, 1, "R6");

        // R3: reset mid-count restarts
        segStart(20'h00005);
        stepTo(3);
        segStart(20'h00006);
        expectAt(6, "R3");
        expectAt(12, "R3");
        segEnd(12, "R3");

        // R4: change mid-period takes effect at next boundary
        segStart(20'h00007);
        expectAt(7, "R4");
        stepTo(3);
        ratioBcd = 20'h00003;
        expectAt(10, "R4");
        expectAt(13, "R4");
        segEnd(13, "R4");

        // R4: change inside the pulse cycle sets the next period
        segStart(20'h00004);
        expectAt(4, "R4");
        stepTo(4);
        ratioBcd = 20'h00006;
        expectAt(10, "R4");
        expectAt(16, "R4");
        segEnd(16, "R4");

        // R4: change just after the pulse cycle waits one more period
        segStart(20'h00004);
        expectAt(4, "R4");
        expectAt(8, "R4");
        stepTo(5);
        ratioBcd = 20'h00009;
        expectAt(17, "R4");
        segEnd(17, "R4");

        // R4 R5: 5 -> 1 at a reload
        segStart(20'h00005);
        expectAt(5, "R5");
        stepTo(2);
        ratioBcd = 20'h00001;
        for (int k = 6; k <= 8; k++) expectAt(k, "R5");
        segEnd(8, "R5");

        // R4 R5: 1 -> 4 changed inside a pulse cycle
        segStart(20'h00001);
        for (int k = 1; k <= 3; k++) expectAt(k, "R5");
        stepTo(3);
        ratioBcd = 20'h00004;
        expectAt(7, "R4");
        expectAt(11, "R4");
        segEnd(11, "R4");
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog expired actual hung expected completion");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_any
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule